// File: doc/BRIEF.md
# Packed Decimal / Binary Integer Converter

This block converts, in either direction, between a ten-byte packed-decimal operand and a 64-bit two's-complement integer. The packed operand holds eighteen decimal digits in nine digit bytes, two digits per byte, with byte 0 the least significant. A tenth byte carries the sign.

A single-cycle start pulse launches a conversion. A direction bit chosen with the pulse selects decode (packed to integer) or encode (integer to packed). The datapath handles one digit byte per clock. A one-cycle done pulse marks the moment the result register for that direction takes its new value.

Decode accumulates from the most significant digit byte downward. Encode peels off base-100 remainders from the least significant byte upward. A host core uses the block in its decimal load and store paths.

Top module: `bcd_int_conv`

## Requirements
- R1: After reset, done_o is 0, int_o is 0 and pkd_o is all zeros.
- R2: Decode: pkd_i bits [8k+7:8k], for k from 0 to 8, form digit byte k. Its high nibble is the tens digit and its low nibble is the units digit. Byte 0 is the least significant. With sign bit pkd_i[79] clear, int_o becomes the sum over k of (10*high + low) * 100^k.
- R3: Decode: when pkd_i[79] is set, int_o is the two's-complement negation of the R2 magnitude. Bits [78:72] have no effect on the result.
- R4: Decode: nibbles above 9 are not rejected. Each is used at its raw value with the R2 weights, and the sum wraps modulo 2^64.
- R5: Encode of a non-negative int_i: pkd_o[79:72] = 0x00. Digit byte k (at bits [8k+7:8k]) holds the k-th base-100 digit of the value, with the tens digit in the high nibble and the units digit in the low nibble. Every digit nibble is at most 9.
- R6: Encode of a negative int_i: pkd_o[79:72] = 0x80, and the digit bytes encode the magnitude |int_i|. Only the low 18 decimal digits are kept, so for -2^63 the bytes hold 2^63 mod 10^18.
- R7: Encode: every digit byte above the most significant non-zero base-100 digit is 0x00, and encoding zero gives all ten bytes 0x00.
- R8: Start is sampled at a rising edge while the block is idle. done_o is high for exactly one cycle, after the ninth rising edge that follows that edge. The result register updates at that same edge.
- R9: A start that arrives while a conversion is in progress is ignored. The result is neither changed nor delayed.
- R10: Decode writes only int_o and encode writes only pkd_o. Both outputs hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| dir_store_i | input | 1 | 1 = encode integer to packed, 0 = decode packed to integer |
| pkd_i | input | 80 | Packed-decimal operand for decode |
| int_i | input | 64 | Signed integer operand for encode |
| done_o | output | 1 | One-cycle completion pulse |
| int_o | output | 64 | Decoded signed integer |
| pkd_o | output | 80 | Encoded packed-decimal result |

## Verification
The start edge is followed by nine stepping edges. The bench therefore expects done_o low at each of the nine falling edges after the start edge, and high only at the tenth falling edge, where it also compares the result register. At the eleventh falling edge it checks that the pulse has ended. Some runs inject a second start three cycles into a conversion, and the bench confirms that the original result still lands on that same tenth falling edge. Values are compared once the pulse is seen, and again later to confirm that they hold and that the other direction's register is untouched.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_BYTES = 9;
    localparam int INT_W       = 64;
    localparam int PKD_W       = (DIGIT_BYTES + 1) * 8;
    localparam int BUF_W       = DIGIT_BYTES * 8;
    localparam int CNT_W       = $clog2(DIGIT_BYTES + 1);

    typedef struct packed {
        logic               busy;
        logic               store;
        logic               neg;
        logic [CNT_W-1:0]   cnt;
        logic [INT_W-1:0]   acc;
        logic [BUF_W-1:0]   shreg;
        logic               done;
        logic [INT_W-1:0]   int_res;
        logic [PKD_W-1:0]   pkd_res;
    } conv_state_t;
endpackage

// File: rtl/bcd_load_step.sv
// One decode step: acc * 100 + tens * 10 + units, raw nibbles, wrap modulo 2^W.
module bcd_load_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] acc_i,
    input  logic [7:0]   byte_i,
    output logic [W-1:0] acc_o
);
    always_comb begin
        acc_o = acc_i * W'(100) + W'(byte_i[7:4]) * W'(10) + W'(byte_i[3:0]);
    end
endmodule

// File: rtl/bcd_store_step.sv
// One encode step: split off the lowest base-100 digit as a packed byte.
module bcd_store_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] mag_i,
    output logic [W-1:0] quot_o,
    output logic [7:0]   byte_o
);
    logic [W-1:0] rem_full;
    logic [6:0]   rem7;

    always_comb begin
        quot_o   = mag_i / W'(100);
        rem_full = mag_i % W'(100);
        rem7     = rem_full[6:0];
        byte_o   = {4'(rem7 / 7'd10), 4'(rem7 % 7'd10)};
    end
endmodule

// File: rtl/bcd_int_conv.sv
module bcd_int_conv
    import bcd_pkg::*;
#(
    parameter int DIG_BYTES = DIGIT_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               dir_store_i,
    input  logic [PKD_W-1:0]   pkd_i,
    input  logic [INT_W-1:0]   int_i,
    output logic               done_o,
    output logic [INT_W-1:0]   int_o,
    output logic [PKD_W-1:0]   pkd_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DIG_BYTES - 1);

    conv_state_t st_d, st_q;

    logic [INT_W-1:0] load_acc;
    logic [INT_W-1:0] store_quot;
    logic [7:0]       store_byte;
    logic             sign_rest_unused;

    assign sign_rest_unused = ^pkd_i[PKD_W-2 -: 7];

    bcd_load_step #(.W(INT_W)) u_load (
        .acc_i  (st_q.acc),
        .byte_i (st_q.shreg[BUF_W-1 -: 8]),
        .acc_o  (load_acc)
    );

    bcd_store_step #(.W(INT_W)) u_store (
        .mag_i  (st_q.acc),
        .quot_o (store_quot),
        .byte_o (store_byte)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.store = dir_store_i;
                st_d.cnt   = '0;
                if (dir_store_i) begin
                    st_d.neg   = int_i[INT_W-1];
                    st_d.acc   = int_i[INT_W-1] ? (~int_i + INT_W'(1)) : int_i;
                    st_d.shreg = '0;
                end else begin
                    st_d.neg   = pkd_i[PKD_W-1];
                    st_d.acc   = '0;
                    st_d.shreg = pkd_i[BUF_W-1:0];
                end
            end
        end else begin
            if (st_q.store) begin
                st_d.acc   = store_quot;
                st_d.shreg = {store_byte, st_q.shreg[BUF_W-1:8]};
            end else begin
                st_d.acc   = load_acc;
                st_d.shreg = {st_q.shreg[BUF_W-9:0], 8'h00};
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST_CNT) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (st_q.store) begin
                    st_d.pkd_res = {st_q.neg ? 8'h80 : 8'h00, store_byte, st_q.shreg[BUF_W-1:8]};
                end else begin
                    st_d.int_res = st_q.neg ? (~load_acc + INT_W'(1)) : load_acc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign int_o  = st_q.int_res;
    assign pkd_o  = st_q.pkd_res;

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(st_q.busy));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start_i && st_q.cnt != LAST_CNT) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(int_o) && $stable(pkd_o)));

    assert_digit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.store) |-> (store_byte[7:4] <= 4'd9 && store_byte[3:0] <= 4'd9));
endmodule

// File: tb/bcd_int_conv_tb_top.sv
module bcd_int_conv_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_store_i = 1'b0;
    logic [79:0] pkd_i = '0;
    logic [63:0] int_i = '0;
    logic        done_o;
    logic [63:0] int_o;
    logic [79:0] pkd_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bcd_int_conv dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_store_i(dir_store_i),
        .pkd_i(pkd_i), .int_i(int_i), .done_o(done_o), .int_o(int_o), .pkd_o(pkd_o)
    );

    function automatic logic [63:0] decode_model(input logic [79:0] p);
        logic [63:0] acc = '0;
        for (int k = 8; k >= 0; k--) begin
            acc = acc * 64'd100 + 64'(p[8*k+4 +: 4]) * 64'd10 + 64'(p[8*k +: 4]);
        end
        if (p[79]) acc = -acc;
        return acc;
    endfunction

    function automatic logic [79:0] encode_model(input logic [63:0] v);
        logic [79:0] p = '0;
        logic [63:0] m = v[63] ? -v : v;
        for (int k = 0; k < 9; k++) begin
            p[8*k+4 +: 4] = 4'((m % 64'd100) / 64'd10);
            p[8*k +: 4]   = 4'(m % 64'd10);
            m = m / 64'd100;
        end
        p[79:72] = v[63] ? 8'h80 : 8'h00;
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one conversion; checks pulse timing (R8), result, and the untouched register (R10).
    task automatic run_op(input bit store, input logic [79:0] p, input logic [63:0] v,
                          input bit inject, input string req);
        logic [63:0] old_int = int_o;
        logic [79:0] old_pkd = pkd_o;
        @(negedge clk);
        dir_store_i = store; pkd_i = p; int_i = v; start_i = 1'b1;
        for (int n = 1; n <= 9; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (inject && n == 3) begin
                start_i = 1'b1; dir_store_i = ~store; pkd_i = ~p; int_i = ~v;
            end
            if (done_o) check(1'b0, "R8 early done", 80'(done_o), 80'd0);
        end
        start_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b1, "R8 done at 9 cycles", 80'(done_o), 80'd1);
        if (store) begin
            check(pkd_o == encode_model(v), req, pkd_o, encode_model(v));
            check(int_o == old_int, "R10 int_o untouched by encode", 80'(int_o), 80'(old_int));
        end else begin
            check(int_o == decode_model(p), req, 80'(int_o), 80'(decode_model(p)));
            check(pkd_o == old_pkd, "R10 pkd_o untouched by decode", pkd_o, old_pkd);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", 80'(done_o), 80'd0);
    endtask

    function automatic logic [79:0] rand_bcd(input bit neg);
        logic [79:0] p = '0;
        for (int k = 0; k < 18; k++) p[4*k +: 4] = 4'($urandom % 10);
        p[79] = neg;
        return p;
    endfunction

    initial begin
        logic [63:0] r64;
        logic [63:0] hold_int;
        logic [79:0] hold_pkd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(done_o == 1'b0, "R1 done reset", 80'(done_o), 80'd0);
        check(int_o == 64'd0, "R1 int_o reset", 80'(int_o), 80'd0);
        check(pkd_o == 80'd0, "R1 pkd_o reset", pkd_o, 80'd0);

        // R2 decode directed
        run_op(1'b0, 80'h00_123456789012345678, 64'd0, 1'b0, "R2 decode digits");
        run_op(1'b0, 80'h00_999999999999999999, 64'd0, 1'b0, "R2 decode max");
        run_op(1'b0, 80'h00_000000000000000000, 64'd0, 1'b0, "R2 decode zero");
        // R3 negative, other sign-byte bits ignored
        run_op(1'b0, 80'h80_000000000000000001, 64'd0, 1'b0, "R3 decode minus one");
        run_op(1'b0, 80'hFF_000000000000004321, 64'd0, 1'b0, "R3 sign byte extra bits");
        run_op(1'b0, 80'h7F_000000000000004321, 64'd0, 1'b0, "R3 positive with junk bits");
        // R4 raw nibbles above 9, wrap
        run_op(1'b0, 80'h00_FFFFFFFFFFFFFFFFFF, 64'd0, 1'b0, "R4 all-F nibbles");
        run_op(1'b0, 80'h80_0000000000000000AB, 64'd0, 1'b0, "R4 neg raw nibbles");

        // R5/R6/R7 encode directed
        run_op(1'b1, 80'd0, 64'd1234, 1'b0, "R7 zero fill above 1234");
        check(pkd_o[79:16] == 64'd0, "R7 upper bytes zero", pkd_o, 80'h0000_0000_0000_0000_1234);
        run_op(1'b1, 80'd0, 64'd0, 1'b0, "R7 encode zero");
        check(pkd_o == 80'd0, "R7 encode zero all bytes", pkd_o, 80'd0);
        run_op(1'b1, 80'd0, 64'd999999999999999999, 1'b0, "R5 encode max 18 digits");
        run_op(1'b1, 80'd0, -64'sd1, 1'b0, "R6 encode minus one");
        check(pkd_o == 80'h80_000000000000000001, "R6 minus one literal", pkd_o, 80'h80_000000000000000001);
        run_op(1'b1, 80'd0, 64'h8000_0000_0000_0000, 1'b0, "R6 most negative truncated");
        run_op(1'b1, 80'd0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R5 largest positive");

        // R9 start during conversion ignored
        run_op(1'b0, 80'h00_000000000087654321, 64'd0, 1'b1, "R9 decode with injected start");
        run_op(1'b1, 80'd0, 64'd5550001, 1'b1, "R9 encode with injected start");

        // R10 hold between pulses
        hold_int = int_o; hold_pkd = pkd_o;
        repeat (7) @(negedge clk);
        check(int_o == hold_int, "R10 int_o holds", 80'(int_o), 80'(hold_int));
        check(pkd_o == hold_pkd, "R10 pkd_o holds", pkd_o, hold_pkd);

        // random mix
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 2) begin
                run_op(1'b0, rand_bcd(1'($urandom % 2)), 64'd0, 1'($urandom % 4 == 0), "R2 R3 random decode");
            end else begin
                r64 = {$urandom, $urandom};
                if ($urandom % 3 == 0) r64 = r64 >> ($urandom % 64);
                run_op(1'b1, 80'd0, r64, 1'($urandom % 4 == 0), "R5 R6 random encode");
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule